// File: doc/BRIEF.md
# Scanline Interrupt Sequencer

This block tracks a video controller's horizontal position within a line and counts lines within a frame. From these it raises a raster-compare interrupt and a vertical-blank interrupt at fixed points of the line. The horizontal position is a four-phase machine: sync width, display start, display width and display end. Each phase lasts a programmed number of controller clocks.

An external horizontal sync can pull the machine back into display start early. The sync-width phase is the one exception: it is only a timeout window and ignores the sync input. Both interrupts are placed relative to the display-width phase alone. The raster compare fires a fixed lead of 12 clocks before that phase ends. Vertical blank fires where display start hands over to display width on the first line past the visible area. Because of this, the lengths of the other three phases never shift either interrupt.

A one-cycle strobe marks the natural end of display width. It tells the scroll and control registers to latch their values for the next line. With a 455-clock line and a 320-clock display width, the raster interrupt falls in clock 308 of the display-width phase.

Top module: `scanline_irq_seq`

## Requirements
- R1: The phase output steps sync width (0) → display start (1) → display width (2) → display end (3) → sync width. Each phase lasts its programmed length in clocks, and a length of 0 counts as 1.
- R2: A rising edge on `ext_hsync` seen while the phase is not 0 makes the next phase 1, with a fresh full display-start period.
- R3: A rising edge on `ext_hsync` seen during phase 0 is ignored. Phase 0 runs its full length.
- R4: `line` increases by one on every entry into phase 1, whether natural or forced by sync. It wraps at 2^LW. A `frame_start` pulse sets it to 0 and takes priority over the increment.
- R5: `stat_rc` is set on the clock after display-width clock index `dw_len-12` (index 0 when `dw_len` ≤ 12). This happens only if `line + 64` (mod 2^LW) equals `raster_cmp`. The set therefore lands `dw_len-11` clocks after phase 2 is entered, whatever `sw_len`, `ds_len` and `de_len` are.
- R6: `stat_vb` is set on the same clock edge on which phase 1 naturally passes to phase 2, when `line` equals `disp_lines`.
- R7: Each status flag stays set until its clear input is high at a clock edge. If a set and a clear occur on the same edge, the set wins.
- R8: `irq` is high exactly when (`stat_rc` and `en_rc`) or (`stat_vb` and `en_vb`).
- R9: `shadow_ld` is high for exactly the first clock of phase 3 after display width ends naturally. A sync snap out of phase 2 gives no strobe.
- R10: While reset is held, the phase is 0, `line` is 0, and both flags, `irq` and `shadow_ld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_hsync | input | 1 | External horizontal sync; its rising edge is acted on |
| frame_start | input | 1 | Vertical frame start; clears the line counter |
| sw_len | input | CW | Sync-width length in clocks |
| ds_len | input | CW | Display-start length in clocks |
| dw_len | input | CW | Display-width length in clocks |
| de_len | input | CW | Display-end length in clocks |
| disp_lines | input | LW | Number of displayed lines |
| raster_cmp | input | LW | Raster compare value (line + 64) |
| en_rc | input | 1 | Raster interrupt enable |
| en_vb | input | 1 | Vertical-blank interrupt enable |
| clr_rc | input | 1 | Clears the raster flag |
| clr_vb | input | 1 | Clears the vertical-blank flag |
| phase | output | 2 | Current horizontal phase (0..3) |
| line | output | LW | Current line number |
| stat_rc | output | 1 | Raster-compare flag |
| stat_vb | output | 1 | Vertical-blank flag |
| irq | output | 1 | Interrupt request |
| shadow_ld | output | 1 | Scroll-register shadow-load strobe |

## Verification
A wrong phase counter or wrong phase state shows on `phase` within the same line, at the first boundary that falls on the wrong clock. The interrupt flags and the shadow strobe then move by the same number of clocks. A wrong line count stays hidden until a raster match or the vertical-blank line is reached, and it then appears as a flag missing on the expected line or set on another one. A bad sync-edge detector shows one clock after the sync pulse, as a phase that fails to snap or snaps during sync width.

// File: rtl/scanline_irq_seq.sv
module scanline_irq_seq #(
  parameter int CW     = 10,
  parameter int LW     = 9,
  parameter int LEAD   = 12,
  parameter int RC_OFS = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_hsync,
  input  logic          frame_start,
  input  logic [CW-1:0] sw_len,
  input  logic [CW-1:0] ds_len,
  input  logic [CW-1:0] dw_len,
  input  logic [CW-1:0] de_len,
  input  logic [LW-1:0] disp_lines,
  input  logic [LW-1:0] raster_cmp,
  input  logic          en_rc,
  input  logic          en_vb,
  input  logic          clr_rc,
  input  logic          clr_vb,
  output logic [1:0]    phase,
  output logic [LW-1:0] line,
  output logic          stat_rc,
  output logic          stat_vb,
  output logic          irq,
  output logic          shadow_ld
);

  localparam logic [1:0] SW = 2'd0, DS = 2'd1, DW = 2'd2, DE = 2'd3;
  localparam logic [CW-1:0] LEAD_C = CW'(LEAD);
  localparam logic [LW-1:0] OFS_C  = LW'(RC_OFS);

  logic [1:0]    ph_q;
  logic [CW-1:0] cnt_q;
  logic [LW-1:0] line_q;
  logic          sync_q, rc_q, vb_q, sh_q;

  logic [CW-1:0] cur_len, rc_pt;
  logic          last, edge_s, snap, ds_entry, rc_hit, vb_hit, dw_done;

  always_comb begin
    case (ph_q)
      SW:      cur_len = sw_len;
      DS:      cur_len = ds_len;
      DW:      cur_len = dw_len;
      default: cur_len = de_len;
    endcase
  end

  assign last     = ({1'b0, cnt_q} + 1'b1) >= {1'b0, cur_len};
  assign edge_s   = ext_hsync & ~sync_q;
  assign snap     = edge_s & (ph_q != SW);
  assign ds_entry = snap | (last & (ph_q == SW));
  assign dw_done  = (ph_q == DW) & last & ~snap;
  assign rc_pt    = (dw_len > LEAD_C) ? dw_len - LEAD_C : '0;
  assign rc_hit   = (ph_q == DW) && (cnt_q == rc_pt) && (LW'(line_q + OFS_C) == raster_cmp);
  assign vb_hit   = (ph_q == DS) && last && !snap && (line_q == disp_lines);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= SW;
      cnt_q  <= '0;
      sync_q <= 1'b1;
    end else begin
      sync_q <= ext_hsync;
      if (snap) begin
        ph_q  <= DS;
        cnt_q <= '0;
      end else if (last) begin
        ph_q  <= ph_q + 2'd1;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           line_q <= '0;
    else if (frame_start) line_q <= '0;
    else if (ds_entry)    line_q <= line_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_q <= 1'b0;
      vb_q <= 1'b0;
      sh_q <= 1'b0;
    end else begin
      rc_q <= rc_hit | (rc_q & ~clr_rc);
      vb_q <= vb_hit | (vb_q & ~clr_vb);
      sh_q <= dw_done;
    end
  end

  assign phase     = ph_q;
  assign line      = line_q;
  assign stat_rc   = rc_q;
  assign stat_vb   = vb_q;
  assign shadow_ld = sh_q;
  assign irq       = (rc_q & en_rc) | (vb_q & en_vb);

  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != $past(ph_q)) |-> ((ph_q == 2'($past(ph_q) + 2'd1)) || (ph_q == DS))); // R1
  AST_SNAP_TO_DS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(snap) |-> (ph_q == DS && cnt_q == '0)); // R2
  AST_SW_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ph_q == SW && !last) |-> (ph_q == SW)); // R3
  AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_start) |-> (line_q == '0)); // R4
  AST_VB_AT_DW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vb_q) |-> (ph_q == DW && $past(ph_q) == DS)); // R6
  AST_RC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rc_q && !clr_rc) |-> rc_q); // R7
  AST_SHADOW_AFTER_DW: assert property (@(posedge clk) disable iff (!rst_n)
    sh_q |-> (ph_q == DE && $past(ph_q) == DW)); // R9

endmodule

// File: tb/scanline_irq_seq_test.sv
module scanline_irq_seq_test;
  localparam int PER = 10;
  localparam int CW = 10, LW = 9;

  logic clk = 0, rst_n, ext_hsync = 0, frame_start = 0;
  logic [CW-1:0] sw_len, ds_len, dw_len, de_len;
  logic [LW-1:0] disp_lines, raster_cmp;
  logic en_rc = 0, en_vb = 0, clr_rc = 0, clr_vb = 0;
  logic [1:0] phase;
  logic [LW-1:0] line;
  logic stat_rc, stat_vb, irq, shadow_ld;

  int compared = 0, mismatched = 0, cyc = 0;
  int mph = 0, mcnt = 0, mline = 0, len, rcpt;
  bit mrc = 0, mvb = 0, msh = 0, msync = 1, lst, snp, rch, vbh, dsin;
  int dw_enter = 0, rc_rise = -1, vb_rise = -1;
  int prev_ph = 0; bit prev_rc = 0, prev_vb = 0;

  scanline_irq_seq #(.CW(CW), .LW(LW)) uut (.*);

  always #(PER/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // reference model
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mph = 0; mcnt = 0; mline = 0; mrc = 0; mvb = 0; msh = 0; msync = 1;
    end else begin
      len  = (mph == 0) ? sw_len : (mph == 1) ? ds_len : (mph == 2) ? dw_len : de_len;
      lst  = (mcnt + 1 >= len);
      snp  = ext_hsync && !msync && mph != 0;
      rcpt = (dw_len > 12) ? dw_len - 12 : 0;
      rch  = (mph == 2) && (mcnt == rcpt) && (((mline + 64) % 512) == raster_cmp);
      vbh  = (mph == 1) && lst && !snp && (mline == disp_lines);
      dsin = snp || (lst && mph == 0);
      msh  = (mph == 2) && lst && !snp;
      mrc  = rch || (mrc && !clr_rc);
      mvb  = vbh || (mvb && !clr_vb);
      if (frame_start) mline = 0; else if (dsin) mline = (mline + 1) % 512;
      if (snp) begin mph = 1; mcnt = 0; end
      else if (lst) begin mph = (mph + 1) % 4; mcnt = 0; end
      else mcnt++;
      msync = ext_hsync;
    end
  end

  // per-clock comparison and event monitor
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 phase", phase, mph);
      chk("R4 line", line, mline);
      chk("R5 stat_rc", stat_rc, mrc);
      chk("R6 stat_vb", stat_vb, mvb);
      chk("R8 irq", irq, (mrc && en_rc) || (mvb && en_vb));
      chk("R9 shadow_ld", shadow_ld, msh);
      if (phase == 2 && prev_ph != 2) dw_enter = cyc;
      if (stat_rc && !prev_rc) rc_rise = cyc;
      if (stat_vb && !prev_vb) vb_rise = cyc;
      prev_ph = phase; prev_rc = stat_rc; prev_vb = stat_vb;
    end
  end

  initial begin
    #(PER * 150000);
    chk("watchdog", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_phase(int p);
    for (int i = 0; i < 3000; i++) begin
      if (phase == 2'(p)) return;
      step(1);
    end
  endtask

  task automatic new_frame();
    clr_rc = 1; clr_vb = 1; frame_start = 1;
    step(1);
    clr_rc = 0; clr_vb = 0; frame_start = 0;
    rc_rise = -1; vb_rise = -1;
  endtask

  task automatic measure(string tag, int exp_delta);
    new_frame();
    for (int i = 0; i < 4000 && (rc_rise < 0 || vb_rise < 0); i++) step(1);
    chk({tag, " R5 rc lead"}, rc_rise - dw_enter + ((vb_rise == dw_enter) ? 0 : 0), exp_delta);
  endtask

  initial begin
    int d;
    rst_n = 0;
    sw_len = 4; ds_len = 6; dw_len = 20; de_len = 5;
    disp_lines = 3; raster_cmp = 9'd65;
    step(3);
    // R10 reset state
    chk("R10 phase", phase, 0);
    chk("R10 line", line, 0);
    chk("R10 flags", {stat_rc, stat_vb, irq, shadow_ld}, 0);
    rst_n = 1;
    step(1);

    // R5: raster on line 1; lead independent of other lengths
    new_frame();
    for (int i = 0; i < 2000 && rc_rise < 0; i++) step(1);
    d = rc_rise - dw_enter;
    chk("R5 lead dw=20", d, 9);
    ds_len = 11; sw_len = 9; de_len = 2;
    new_frame();
    for (int i = 0; i < 2000 && rc_rise < 0; i++) step(1);
    chk("R5 lead other lengths", rc_rise - dw_enter, 9);
    dw_len = 30;
    new_frame();
    for (int i = 0; i < 2000 && rc_rise < 0; i++) step(1);
    chk("R5 lead dw=30", rc_rise - dw_enter, 19);
    dw_len = 8;
    new_frame();
    for (int i = 0; i < 2000 && rc_rise < 0; i++) step(1);
    chk("R5 short dw", rc_rise - dw_enter, 1);
    dw_len = 20;

    // R6: vblank coincides with phase 2 entry on line disp_lines
    new_frame();
    for (int i = 0; i < 3000 && vb_rise < 0; i++) step(1);
    chk("R6 vb at dw entry", vb_rise, dw_enter);
    chk("R6 vb line", line, 3);

    // R7 sticky, R8 enables
    step(200);
    chk("R7 vb sticky", stat_vb, 1);
    en_vb = 1; step(1);
    chk("R8 irq on", irq, 1);
    en_vb = 0; step(1);
    chk("R8 irq masked", irq, 0);
    clr_vb = 1; step(1); clr_vb = 0;
    chk("R7 vb cleared", stat_vb, 0);

    // R3: sync edge in phase 0 ignored
    sw_len = 20;
    wait_phase(0);
    ext_hsync = 1; step(1); ext_hsync = 0;
    chk("R3 sync in SW ignored", phase, 0);
    // R2: snap from display end and display width
    wait_phase(3);
    ext_hsync = 1; step(1); ext_hsync = 0;
    chk("R2 snap from DE", phase, 1);
    wait_phase(2); step(3);
    ext_hsync = 1; step(1); ext_hsync = 0;
    chk("R2 snap from DW", phase, 1);
    step(1);
    chk("R9 no strobe on snap", shadow_ld, 0);

    // R9 strobe in first DE clock
    wait_phase(3);
    chk("R9 strobe", shadow_ld, 1);
    step(1);
    chk("R9 single", shadow_ld, 0);

    // R1 zero-length phase behaves as one clock
    de_len = 0;
    step(300);

    // full-size line: 455 clocks, 320 display
    sw_len = 32; ds_len = 40; dw_len = 320; de_len = 63; raster_cmp = 9'd66;
    en_rc = 1;
    new_frame();
    for (int i = 0; i < 5000 && rc_rise < 0; i++) step(1);
    chk("R5 lead 320", rc_rise - dw_enter, 309);
    chk("R8 irq rc", irq, 1);
    step(2000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule